// File: doc/BRIEF.md
# Dual Data Pointer Register Bank

This block keeps two separate 16-bit data pointers for an 8-bit microcontroller core. One pointer is active at any time, and the external data address output always shows that pointer. Software picks the active pointer through a select bit in an auxiliary special-function register (SFR). Both pointers share one pair of SFR byte addresses, so the same code path reaches whichever pointer is currently selected.

The core reaches the bank in two ways. It reads and writes the high and low pointer bytes and the auxiliary register over a byte-wide SFR port. It also issues a 16-bit immediate load command and an increment command. Both commands act only on the active pointer. A typical use is a block copy: one pointer holds the source address, the other holds the destination, and one bit flip moves between them.

The auxiliary register also holds a general-purpose flag that software can write and read. The flag has no effect on the pointers.

Top module: `xptr_bank`

## Requirements
- R1: After reset, both pointers are 0x0000, the select bit is 0, the flag is 0, and ext_addr reads 0x0000.
- R2: A write to SFR address 0xA2 copies data bit 0 into the select bit and data bit 3 into the flag. A read of 0xA2 returns the select bit in bit 0, the flag in bit 3 and 0 in every other bit. Writes to the other bits have no effect.
- R3: ext_addr combinationally shows pointer 0 while the select bit is 0, and pointer 1 while it is 1.
- R4: SFR address 0x83 reads and writes the high byte of the selected pointer. SFR address 0x82 reads and writes its low byte. A write to one byte leaves the other byte unchanged.
- R5: A load command writes ld_val into the selected pointer at the next clock edge.
- R6: An increment command adds 1 to the selected pointer. The carry passes from the low byte into the high byte, and 0xFFFF wraps to 0x0000.
- R7: The pointer that is not selected keeps its value through every load, increment and byte write.
- R8: The flag bit has no influence on which pointer is selected.
- R9: In one cycle, an SFR write to 0x82 or 0x83 takes priority over a load, and a load takes priority over an increment. A suppressed command is dropped.
- R10: When an SFR write to 0xA2 arrives in the same cycle as a load or an increment, the command acts on the pointer that was selected before that write.
- R11: A read of any SFR address other than 0x82, 0x83 and 0xA2 returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sfr_addr | input | 8 | SFR address for the read and the write |
| sfr_wr | input | 1 | SFR write strobe |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rdata | output | 8 | SFR read data, combinational on sfr_addr |
| ld_en | input | 1 | Load the selected pointer from ld_val |
| ld_val | input | 16 | Immediate value for a load |
| inc_en | input | 1 | Increment the selected pointer |
| ext_addr | output | 16 | External data address, equal to the selected pointer |

## Verification
The assertions run on every cycle. They check the following: the inactive pointer holds its value, a lone increment or load moves ext_addr as stated, a low-byte write beats the commands, reserved read bits are zero, and the high-byte readback agrees with ext_addr.

Some behaviours only the bench scenarios can show, by driving a run of operations and comparing against its own model. These are the wrap from 0xFFFF, the carry into the high byte, the flag's lack of effect on selection, and commands that land in the same cycle as a select change and therefore use the old pointer.

// File: rtl/xptr_pkg.sv
package xptr_pkg;
   localparam int unsigned SFR_DW   = 8;
   localparam int unsigned SFR_AW   = 8;
   localparam logic [7:0]  A_AUX    = 8'hA2;
   localparam logic [7:0]  A_PTR_HI = 8'h83;
   localparam logic [7:0]  A_PTR_LO = 8'h82;
   localparam int unsigned SEL_POS  = 0;
   localparam int unsigned FLAG_POS = 3;

   typedef enum logic [1:0] {
      OP_NONE = 2'd0,
      OP_BYTE = 2'd1,
      OP_LOAD = 2'd2,
      OP_INCR = 2'd3
   } ptr_op_e;
endpackage

// File: rtl/xptr_aux.sv
module xptr_aux #(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned SEL_POS  = 0,
   parameter int unsigned FLAG_POS = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic              sel_in,
   input  logic              flag_in,
   output logic              sel_q,
   output logic [DATA_W-1:0] rd_val
);
   logic flag_q;

   if (SEL_POS >= DATA_W || FLAG_POS >= DATA_W || SEL_POS == FLAG_POS) begin : g_bad_pos
      $error("xptr_aux: bit positions out of range or overlapping");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q  <= 1'b0;
         flag_q <= 1'b0;
      end else if (wr) begin
         sel_q  <= sel_in;
         flag_q <= flag_in;
      end
   end

   always_comb begin
      rd_val           = '0;
      rd_val[SEL_POS]  = sel_q;
      rd_val[FLAG_POS] = flag_q;
   end
endmodule

// File: rtl/xptr_word.sv
module xptr_word #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned PTR_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_hi,
   input  logic              wr_lo,
   input  logic [DATA_W-1:0] wdata,
   input  logic              ld,
   input  logic [PTR_W-1:0]  ld_val,
   input  logic              inc,
   output logic [PTR_W-1:0]  q
);
   import xptr_pkg::*;

   ptr_op_e op;

   always_comb begin
      if (wr_hi || wr_lo) op = OP_BYTE;
      else if (ld)        op = OP_LOAD;
      else if (inc)       op = OP_INCR;
      else                op = OP_NONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else begin
         unique case (op)
            OP_BYTE: begin
               if (wr_hi) q[PTR_W-1:DATA_W] <= wdata;
               if (wr_lo) q[DATA_W-1:0]     <= wdata;
            end
            OP_LOAD: q <= ld_val;
            OP_INCR: q <= q + PTR_W'(1);
            default: q <= q;
         endcase
      end
   end
endmodule

// File: rtl/xptr_bank.sv
module xptr_bank #(
   parameter int unsigned DATA_W   = xptr_pkg::SFR_DW,
   parameter int unsigned PTR_W    = 16,
   parameter logic [7:0]  AUX_ADDR = xptr_pkg::A_AUX,
   parameter logic [7:0]  HI_ADDR  = xptr_pkg::A_PTR_HI,
   parameter logic [7:0]  LO_ADDR  = xptr_pkg::A_PTR_LO
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [7:0]        sfr_addr,
   input  logic              sfr_wr,
   input  logic [DATA_W-1:0] sfr_wdata,
   output logic [DATA_W-1:0] sfr_rdata,
   input  logic              ld_en,
   input  logic [PTR_W-1:0]  ld_val,
   input  logic              inc_en,
   output logic [PTR_W-1:0]  ext_addr
);
   localparam int unsigned NUM_PTR = 2;

   if (PTR_W != 2 * DATA_W) begin : g_bad_width
      $error("xptr_bank: pointer must be two SFR bytes wide");
   end
   if (AUX_ADDR == HI_ADDR || AUX_ADDR == LO_ADDR || HI_ADDR == LO_ADDR) begin : g_bad_map
      $error("xptr_bank: SFR addresses must differ");
   end

   logic              sel_q;
   logic [DATA_W-1:0] aux_rd;
   logic              hit_aux, hit_hi, hit_lo;
   logic [PTR_W-1:0]  ptr_q [NUM_PTR];

   assign hit_aux = (sfr_addr == AUX_ADDR);
   assign hit_hi  = (sfr_addr == HI_ADDR);
   assign hit_lo  = (sfr_addr == LO_ADDR);

   xptr_aux #(
      .DATA_W  (DATA_W),
      .SEL_POS (xptr_pkg::SEL_POS),
      .FLAG_POS(xptr_pkg::FLAG_POS)
   ) u_aux (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (sfr_wr && hit_aux),
      .sel_in (sfr_wdata[xptr_pkg::SEL_POS]),
      .flag_in(sfr_wdata[xptr_pkg::FLAG_POS]),
      .sel_q  (sel_q),
      .rd_val (aux_rd)
   );

   for (genvar i = 0; i < NUM_PTR; i++) begin : g_ptr
      logic act;
      assign act = (sel_q == 1'(i));
      xptr_word #(
         .DATA_W(DATA_W),
         .PTR_W (PTR_W)
      ) u_word (
         .clk   (clk),
         .rst_n (rst_n),
         .wr_hi (act && sfr_wr && hit_hi),
         .wr_lo (act && sfr_wr && hit_lo),
         .wdata (sfr_wdata),
         .ld    (act && ld_en),
         .ld_val(ld_val),
         .inc   (act && inc_en),
         .q     (ptr_q[i])
      );
   end

   assign ext_addr = ptr_q[sel_q];

   always_comb begin
      if (hit_aux)     sfr_rdata = aux_rd;
      else if (hit_hi) sfr_rdata = ext_addr[PTR_W-1:DATA_W];
      else if (hit_lo) sfr_rdata = ext_addr[DATA_W-1:0];
      else             sfr_rdata = '0;
   end
endmodule

// File: rtl/xptr_bank_chk.sv
module xptr_bank_chk #(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned PTR_W    = 16,
   parameter logic [7:0]  AUX_ADDR = 8'hA2,
   parameter logic [7:0]  HI_ADDR  = 8'h83,
   parameter logic [7:0]  LO_ADDR  = 8'h82
) (
   input logic              clk,
   input logic              rst_n,
   input logic [7:0]        sfr_addr,
   input logic              sfr_wr,
   input logic [DATA_W-1:0] sfr_wdata,
   input logic [DATA_W-1:0] sfr_rdata,
   input logic              ld_en,
   input logic [PTR_W-1:0]  ld_val,
   input logic              inc_en,
   input logic [PTR_W-1:0]  ext_addr,
   input logic              sel_q,
   input logic [PTR_W-1:0]  ptr0_q,
   input logic [PTR_W-1:0]  ptr1_q
);
   logic any_wr;
   assign any_wr = sfr_wr && (sfr_addr == AUX_ADDR || sfr_addr == HI_ADDR
                              || sfr_addr == LO_ADDR);

   assert_inactive0_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      sel_q |=> $stable(ptr0_q));

   assert_inactive1_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_q |=> $stable(ptr1_q));

   assert_increment_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_en && !ld_en && !any_wr) |=> ext_addr == PTR_W'($past(ext_addr) + 1'b1));

   assert_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_en && !any_wr) |=> ext_addr == $past(ld_val));

   assert_byte_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (sfr_wr && sfr_addr == LO_ADDR) |=> ext_addr[DATA_W-1:0] == $past(sfr_wdata));

   assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (sfr_addr == AUX_ADDR) |-> (sfr_rdata & ~DATA_W'(8'h09)) == '0);

   assert_hi_readback_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (sfr_addr == HI_ADDR) |-> sfr_rdata == ext_addr[PTR_W-1:DATA_W]);
endmodule

bind xptr_bank xptr_bank_chk #(
   .DATA_W  (DATA_W),
   .PTR_W   (PTR_W),
   .AUX_ADDR(AUX_ADDR),
   .HI_ADDR (HI_ADDR),
   .LO_ADDR (LO_ADDR)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .sfr_addr (sfr_addr),
   .sfr_wr   (sfr_wr),
   .sfr_wdata(sfr_wdata),
   .sfr_rdata(sfr_rdata),
   .ld_en    (ld_en),
   .ld_val   (ld_val),
   .inc_en   (inc_en),
   .ext_addr (ext_addr),
   .sel_q    (sel_q),
   .ptr0_q   (ptr_q[0]),
   .ptr1_q   (ptr_q[1])
);

// File: tb/xptr_bank_bench.sv
module xptr_bank_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  sfr_addr = '0;
   logic        sfr_wr = 1'b0;
   logic [7:0]  sfr_wdata = '0;
   logic [7:0]  sfr_rdata;
   logic        ld_en = 1'b0;
   logic [15:0] ld_val = '0;
   logic        inc_en = 1'b0;
   logic [15:0] ext_addr;

   int n_checks = 0;
   int n_fail   = 0;

   logic [15:0] m_ptr [2];
   logic        m_sel;
   logic        m_flag;

   always #(CLK_PERIOD/2) clk = ~clk;

   xptr_bank u_xptr_bank (
      .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr),
      .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .ld_en(ld_en),
      .ld_val(ld_val), .inc_en(inc_en), .ext_addr(ext_addr)
   );

   function automatic logic [7:0] exp_rd(input logic [7:0] a);
      if (a == 8'hA2)      return {4'b0, m_flag, 2'b0, m_sel};
      else if (a == 8'h83) return m_ptr[m_sel][15:8];
      else if (a == 8'h82) return m_ptr[m_sel][7:0];
      else                 return 8'h00;
   endfunction

   function automatic string rd_tag(input logic [7:0] a);
      if (a == 8'hA2)                    return "R2";
      else if (a == 8'h83 || a == 8'h82) return "R4";
      else                               return "R11";
   endfunction

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [15:0] act, input logic [15:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic model_step(input bit wr, input logic [7:0] a, input logic [7:0] d,
                             input bit ld, input logic [15:0] lv, input bit inc);
      logic s;
      s = m_sel;
      if (wr && (a == 8'h83 || a == 8'h82)) begin
         if (a == 8'h83) m_ptr[s][15:8] = d;
         else            m_ptr[s][7:0]  = d;
      end else if (ld) begin
         m_ptr[s] = lv;
      end else if (inc) begin
         m_ptr[s] = m_ptr[s] + 16'd1;
      end
      if (wr && a == 8'hA2) begin
         m_sel  = d[0];
         m_flag = d[3];
      end
   endtask

   task automatic cyc(input string tag, input bit wr, input logic [7:0] a,
                      input logic [7:0] d, input bit ld, input logic [15:0] lv,
                      input bit inc);
      sfr_wr = wr; sfr_addr = a; sfr_wdata = d;
      ld_en = ld; ld_val = lv; inc_en = inc;
      #1;
      check(sfr_rdata == exp_rd(a), rd_tag(a), "sfr_rdata", {8'h00, sfr_rdata},
            {8'h00, exp_rd(a)});
      @(posedge clk);
      model_step(wr, a, d, ld, lv, inc);
      @(negedge clk);
      sfr_wr = 1'b0; ld_en = 1'b0; inc_en = 1'b0;
      check(ext_addr == m_ptr[m_sel], tag, "ext_addr", ext_addr, m_ptr[m_sel]);
   endtask

   task automatic rd(input string tag, input logic [7:0] a);
      cyc(tag, 1'b0, a, 8'h00, 1'b0, 16'h0000, 1'b0);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      m_ptr[0] = '0; m_ptr[1] = '0; m_sel = 1'b0; m_flag = 1'b0;
      repeat (3) @(negedge clk);
      check(ext_addr == 16'h0000, "R1", "reset ext_addr", ext_addr, 16'h0000);
      rst_n = 1'b1;
      @(negedge clk);
      rd("R1", 8'hA2);
      rd("R1", 8'h83);
      rd("R1", 8'h82);

      // R5 load then R6 carry into the high byte
      cyc("R5", 1'b0, 8'h00, 8'h00, 1'b1, 16'h12FF, 1'b0);
      cyc("R6", 1'b0, 8'h00, 8'h00, 1'b0, 16'h0000, 1'b1);
      // R3 switch to pointer 1, which must still be zero (R7)
      cyc("R3", 1'b1, 8'hA2, 8'h01, 1'b0, 16'h0000, 1'b0);
      check(ext_addr == 16'h0000, "R7", "idle pointer", ext_addr, 16'h0000);
      // R6 wrap
      cyc("R5", 1'b0, 8'h00, 8'h00, 1'b1, 16'hFFFF, 1'b0);
      cyc("R6", 1'b0, 8'h00, 8'h00, 1'b0, 16'h0000, 1'b1);
      // R2 reserved bits ignored
      cyc("R2", 1'b1, 8'hA2, 8'hFF, 1'b0, 16'h0000, 1'b0);
      rd("R2", 8'hA2);
      // R8 flag set, select cleared: pointer 0 (0x1300) is shown
      cyc("R8", 1'b1, 8'hA2, 8'h08, 1'b0, 16'h0000, 1'b0);
      check(ext_addr == 16'h1300, "R8", "flag no effect", ext_addr, 16'h1300);
      // R9 low byte write beats load and increment
      cyc("R9", 1'b1, 8'h82, 8'h55, 1'b1, 16'hABCD, 1'b1);
      check(ext_addr == 16'h1355, "R9", "priority", ext_addr, 16'h1355);
      cyc("R9", 1'b1, 8'h83, 8'h77, 1'b0, 16'h0000, 1'b1);
      cyc("R9", 1'b0, 8'h00, 8'h00, 1'b1, 16'h2222, 1'b1);
      // R10 select change with increment: old pointer 0 increments
      cyc("R10", 1'b1, 8'hA2, 8'h01, 1'b0, 16'h0000, 1'b1);
      check(ext_addr == 16'h0000, "R10", "new pointer untouched", ext_addr, 16'h0000);
      cyc("R10", 1'b1, 8'hA2, 8'h00, 1'b0, 16'h0000, 1'b0);
      check(ext_addr == 16'h2223, "R10", "old pointer incremented", ext_addr, 16'h2223);
      rd("R11", 8'h90);
      rd("R11", 8'h00);

      for (int k = 0; k < 600; k++) begin
         logic [7:0] a;
         int sel;
         sel = int'($urandom_range(0, 4));
         case (sel)
            0: a = 8'hA2;
            1: a = 8'h83;
            2: a = 8'h82;
            default: a = 8'($urandom());
         endcase
         cyc("R3", 1'($urandom_range(0, 1)), a, 8'($urandom()),
             ($urandom_range(0, 3) == 0), 16'($urandom()), 1'($urandom_range(0, 1)));
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule